// File: doc/BRIEF.md
# System Control Port Register

This block is a one-byte I/O register sitting on a simple host port bus made of an address, a write strobe, a read strobe, write data and read data. It answers at a single port address (0x92 by default) and ignores all other addresses. A write stores the whole byte. A read returns the stored byte unchanged. Two system control outputs are derived from the register:

- An address-line-20 gate enable level, which follows bit 1.
- A one-clock system reset request pulse, fired by any write whose bit 0 is 1.

The block has two resets. The power-up reset `por_n` is asynchronous and active low, and it clears the whole byte. The system reset `sys_rst` is synchronous and active high, and it clears only bit 0. The other seven bits, including the gate enable, keep their values across a system reset.

The reset request is produced by a two-state machine:

- **REQ_IDLE**: the pulse output is low.
- **REQ_FIRE**: the pulse output is high for this cycle.

Its transitions are:

- **T_ARM** (REQ_IDLE to REQ_FIRE): an accepted write with bit 0 set.
- **T_REFIRE** (REQ_FIRE to REQ_FIRE): another accepted write with bit 0 set.
- **T_DONE** (REQ_FIRE to REQ_IDLE): no such write.
- **T_HOLD** (REQ_IDLE to REQ_IDLE): no such write.
- **T_ABORT** (any state to REQ_IDLE): system reset is asserted.

Top module: `sysctl_port`

## Requirements
- R1: While `por_n` is low, the stored byte is 0x00, `a20_en` is 0 and `rst_req` is 0. After release, a read of the port returns 0x00.
- R2: A write with `addr` equal to 0x0092 stores all 8 bits of `wdata` at that clock edge. A read (`rd_en` high) of 0x0092 in a later cycle returns that byte on `rdata` in the same cycle, with no added latency.
- R3: A write to any address other than 0x0092, including addresses that differ only in the upper bits such as 0x0192, leaves the stored byte unchanged.
- R4: `a20_en` equals bit 1 of the stored byte. It changes on the clock edge that completes the write.
- R5: A write of a byte with bit 0 = 1 makes `rst_req` high for exactly the one cycle after the write edge, whatever bit 0 held before. A write with bit 0 = 0 produces no pulse.
- R6: Writes with bit 0 = 1 in consecutive cycles keep `rst_req` high for one cycle per write, that is, for consecutive cycles.
- R7: A system reset clears only bit 0 of the stored byte, keeping bits 7..1 and `a20_en`. It wins over a port write in the same cycle, and that write is discarded.
- R8: `rdata` is 0x00 whenever `rd_en` is low or `addr` is not 0x0092.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| sys_rst | input | 1 | System reset, synchronous, active high; clears bit 0 only |
| addr | input | 16 | Port address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0 when no read hits the port |
| a20_en | output | 1 | Address-line-20 gate enable level (bit 1) |
| rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
The embedded properties are checked on every cycle:

- The stored byte stays stable when there is no accepted write.
- The gate enable register agrees with bit 1 of the byte.
- Every accepted write with bit 0 set is followed by a pulse, and no pulse appears without one.
- A system reset keeps bits 7..1 while clearing bit 0.

Only the bench scenarios can show the following:

- Read data values after mixed sequences of hits and misses.
- Upper-address aliasing being rejected.
- A system reset discarding a write in the same cycle.
- The exact pulse width across back-to-back writes.
- The state after a power-up reset in the middle of a run.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned SC_ADDR_W  = 16;
    localparam int unsigned SC_DATA_W  = 8;
    localparam logic [SC_ADDR_W-1:0] SC_PORT_ADDR = 16'h0092;
    localparam int unsigned SC_GATE_BIT = 1;
    localparam int unsigned SC_KICK_BIT = 0;

    typedef enum logic [0:0] {
        REQ_IDLE = 1'b0,
        REQ_FIRE = 1'b1
    } req_state_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    always_comb begin
        match  = (addr == PORT_ADDR);
        wr_hit = wr_en && match;
        rd_hit = rd_en && match;
    end
endmodule

// File: rtl/sysctl_hold.sv
module sysctl_hold #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned KICK_BIT = 0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] held
);
    localparam int unsigned KEEP_W = DATA_W - 1;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            held <= '0;
        end else if (sys_rst) begin
            held[KICK_BIT] <= 1'b0;
        end else if (wr_hit) begin
            held <= wdata;
        end
    end

    // R3: no accepted write and no system reset leaves the byte untouched
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!por_n)
        (!wr_hit && !sys_rst) |=> $stable(held));

    // R2: an accepted write lands the full byte
    a_r2_full_store: assert property (@(posedge clk) disable iff (!por_n)
        (wr_hit && !sys_rst) |=> (held == $past(wdata)));

    // R7: system reset clears bit 0 only
    a_r7_keep_upper: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (!held[KICK_BIT] && $countones(held ^ $past(held)) <= 1));

    initial begin
        a_r7_width: assert (KEEP_W >= 1);
    end
endmodule

// File: rtl/sysctl_reqfsm.sv
module sysctl_reqfsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic wr_hit,
    input  logic kick_bit,
    output logic rst_req
);
    req_state_t state_q, state_d;
    logic       kick;

    always_comb begin
        kick = wr_hit && kick_bit && !sys_rst;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: state_d = kick ? REQ_FIRE : REQ_IDLE;
            REQ_FIRE: state_d = kick ? REQ_FIRE : REQ_IDLE;
            default:  state_d = REQ_IDLE;
        endcase
        if (sys_rst) begin
            state_d = REQ_IDLE;
        end
    end

    always_comb begin
        rst_req = (state_q == REQ_FIRE);
    end

    // R5: a kicking write is followed by a pulse
    a_r5_pulse_after_kick: assert property (@(posedge clk) disable iff (!por_n)
        (wr_hit && kick_bit && !sys_rst) |=> rst_req);

    // R5: no pulse without a kicking write in the previous cycle
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_hit && kick_bit && !sys_rst) |=> !rst_req);
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = SC_ADDR_W,
    parameter int unsigned DATA_W   = SC_DATA_W,
    parameter logic [ADDR_W-1:0] PORT_ADDR = SC_PORT_ADDR,
    parameter int unsigned GATE_BIT = SC_GATE_BIT,
    parameter int unsigned KICK_BIT = SC_KICK_BIT
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              a20_en,
    output logic              rst_req
);
    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] held;
    logic              gate_q;

    sysctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    sysctl_hold #(.DATA_W(DATA_W), .KICK_BIT(KICK_BIT)) u_hold (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .wr_hit  (wr_hit),
        .wdata   (wdata),
        .held    (held)
    );

    sysctl_reqfsm u_reqfsm (
        .clk      (clk),
        .por_n    (por_n),
        .sys_rst  (sys_rst),
        .wr_hit   (wr_hit),
        .kick_bit (wdata[KICK_BIT]),
        .rst_req  (rst_req)
    );

    // dedicated gate flop, kept next to the pin
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            gate_q <= 1'b0;
        end else if (wr_hit && !sys_rst) begin
            gate_q <= wdata[GATE_BIT];
        end
    end

    always_comb begin
        a20_en = gate_q;
        rdata  = rd_hit ? held : '0;
    end

    // R4: gate level agrees with the stored byte on every cycle
    a_r4_gate_matches: assert property (@(posedge clk) disable iff (!por_n)
        a20_en == held[GATE_BIT]);

    // R4: gate follows the written bit on the completing edge
    a_r4_gate_update: assert property (@(posedge clk) disable iff (!por_n)
        (wr_hit && !sys_rst) |=> (a20_en == $past(wdata[GATE_BIT])));

    // R7: system reset keeps the gate level
    a_r7_gate_kept: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> $stable(a20_en));

    // R8: no read hit gives zero read data
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!por_n)
        !rd_hit |-> (rdata == '0));
endmodule

// File: tb/sysctl_port_bench.sv
module sysctl_port_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        a20_en;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sysctl_port u_sysctl_port (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .a20_en  (a20_en),
        .rst_req (rst_req)
    );

    // {write addr, write data, read addr, exp rdata, exp a20, exp pulse}
    localparam int NVEC = 8;
    localparam logic [49:0] VECS [NVEC] = '{
        {16'h0092, 8'h02, 16'h0092, 8'h02, 1'b1, 1'b0},
        {16'h0092, 8'h01, 16'h0092, 8'h01, 1'b0, 1'b1},
        {16'h0093, 8'hFF, 16'h0092, 8'h01, 1'b0, 1'b0},
        {16'h0092, 8'hA6, 16'h0092, 8'hA6, 1'b1, 1'b0},
        {16'h0092, 8'h5B, 16'h0093, 8'h00, 1'b1, 1'b1},
        {16'h0192, 8'h00, 16'h0092, 8'h5B, 1'b1, 1'b0},
        {16'h0092, 8'hFF, 16'h0092, 8'hFF, 1'b1, 1'b1},
        {16'h0092, 8'h00, 16'h0092, 8'h00, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a);
        addr = a; rd_en = 1'b1;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R1 a20", {7'd0, a20_en}, 8'h00);
        check("R1 pulse", {7'd0, rst_req}, 8'h00);
        por_n = 1'b1;
        @(negedge clk);
        do_read(16'h0092);
        check("R1 read", rdata, 8'h00);
        rd_en = 1'b0;

        // table walk: R2 R3 R4 R5 R8
        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i][49:34], VECS[i][33:26]);
            do_read(VECS[i][25:10]);
            check("R2/R3/R8 rdata", rdata, VECS[i][9:2]);
            check("R4 a20", {7'd0, a20_en}, {7'd0, VECS[i][1]});
            check("R5 pulse", {7'd0, rst_req}, {7'd0, VECS[i][0]});
            @(negedge clk);
            rd_en = 1'b0;
            #1;
            check("R5 one cycle", {7'd0, rst_req}, 8'h00);
        end

        // R8: rd_en low gives zero
        addr = 16'h0092; rd_en = 1'b0;
        #1;
        check("R8 no strobe", rdata, 8'h00);

        // R6: back-to-back kicks
        @(negedge clk);
        addr = 16'h0092; wdata = 8'h03; wr_en = 1'b1;
        @(negedge clk);
        #1;
        check("R6 first", {7'd0, rst_req}, 8'h01);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R6 second", {7'd0, rst_req}, 8'h01);
        @(negedge clk);
        #1;
        check("R6 end", {7'd0, rst_req}, 8'h00);

        // R7: system reset keeps bits 7..1
        do_write(16'h0092, 8'hA7);
        @(negedge clk);
        sys_rst = 1'b1;
        @(negedge clk);
        sys_rst = 1'b0;
        do_read(16'h0092);
        check("R7 keep", rdata, 8'hA6);
        check("R7 a20", {7'd0, a20_en}, 8'h01);
        rd_en = 1'b0;

        // R7: system reset beats a same-cycle write
        @(negedge clk);
        addr = 16'h0092; wdata = 8'h01; wr_en = 1'b1; sys_rst = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sys_rst = 1'b0;
        #1;
        check("R7 no pulse", {7'd0, rst_req}, 8'h00);
        do_read(16'h0092);
        check("R7 write dropped", rdata, 8'hA6);
        rd_en = 1'b0;

        // R1: power-up reset mid-run
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        do_read(16'h0092);
        check("R1 re-reset", rdata, 8'h00);
        check("R1 re-reset a20", {7'd0, a20_en}, 8'h00);
        rd_en = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule